// File: doc/BRIEF.md
# Serial BCH(31,16) Syndrome Generator

This block is the first stage of a receiver for a binary BCH code of length 31 that carries 16 message bits and 15 parity bits and corrects up to three bit errors. It takes a received codeword one bit per enabled clock and evaluates the received polynomial at the first six powers of a primitive element of GF(32). The result is six 5-bit field elements, S1 to S6, plus a flag that reads high when all six are zero, meaning no error was detected.

A single-cycle `startIn` pulse opens a word and clears every syndrome. Each cycle with `validIn` high then delivers one coefficient, highest degree first. Cycles with `validIn` low are gaps. Each syndrome register applies the Horner step S ← S·α^j ⊕ bit with a constant multiplier, so the six values are final as soon as the 31st bit is accepted. `doneOut` pulses in the next cycle, and the outputs then hold until the next start. A later stage (key equation solver and root search) consumes the syndromes.

Top module: `bch_syn_top`

## Requirements
- R1: After reset, all six syndrome outputs are zero, `doneOut` is low and `zeroOut` is high.
- R2: A cycle with `startIn` high makes every syndrome zero in the following cycle. A bit offered with `validIn` in that same cycle is not consumed.
- R3: After 31 accepted bits, syndrome j (j = 1..6, at `synOut[j-1]`) equals r(α^j). Here the first accepted bit is the coefficient of x^30 and the last is that of x^0. α is a root of x^5 + x^2 + 1, and bit k of a 5-bit element is its coefficient of α^k.
- R4: For a valid codeword (all-zero or all-ones word), all six syndromes are zero and `zeroOut` is high.
- R5: `doneOut` is high for exactly one cycle, the cycle immediately after the 31st accepted bit.
- R6: Cycles with `validIn` low between bits of a word change no syndrome and do not count as bits.
- R7: Once 31 bits have been accepted, further `validIn` cycles are ignored. The syndromes hold and `doneOut` stays low until the next start.
- R8: After reset and before the first start, `validIn` cycles are ignored.
- R9: For any received word, after the word is complete, S2 = S1², S4 = S2² and S6 = S3² in GF(32).
- R10: `zeroOut` is low whenever any syndrome output is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Synchronous start of a new word; clears syndromes |
| validIn | input | 1 | `bitIn` carries a codeword bit this cycle |
| bitIn | input | 1 | Serial codeword bit, highest degree first |
| synOut | output | 6x5 | Syndromes; `synOut[j-1]` is S_j |
| zeroOut | output | 1 | High when all syndromes are zero |
| doneOut | output | 1 | One-cycle pulse after the last bit of a word |

## Verification
The evaluation is driven with the all-zero and all-ones words, which are codewords and must give an all-zero set. It is also driven with single-error and triple-error patterns and pseudo-random words. Each of these is compared against a bench-side power-sum evaluation, which separates a wrong multiplier constant or a reversed bit order from a correct datapath. The same word is also sent with gap cycles, and once again after a start that cuts off a partial word, to show that only accepted bits count. Extra bits after completion, bits before the first start, and a bit offered together with start check that the framing ignores what it should.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;

  localparam int GF_M      = 5;
  localparam logic [GF_M-1:0] GF_POLY_TAIL = 5'b00101; // x^5 + x^2 + 1 without x^5
  localparam int CODE_N    = (1 << GF_M) - 1;
  localparam int NUM_SYN   = 6;

  typedef struct packed {
    logic clear;
    logic shift;
  } synStrobe_t;

  function automatic logic [GF_M-1:0] gfTimesAlpha(input logic [GF_M-1:0] x);
    logic [GF_M-1:0] r;
    r = {x[GF_M-2:0], 1'b0};
    if (x[GF_M-1]) r = r ^ GF_POLY_TAIL;
    return r;
  endfunction

  // multiply by alpha^k for small constant k
  function automatic logic [GF_M-1:0] gfTimesAlphaPow(input logic [GF_M-1:0] x,
                                                        input int k);
    logic [GF_M-1:0] r;
    r = x;
    for (int i = 0; i < NUM_SYN; i++) begin
      if (i < k) r = gfTimesAlpha(r);
    end
    return r;
  endfunction

  function automatic logic [GF_M-1:0] gfMul(input logic [GF_M-1:0] a,
                                            input logic [GF_M-1:0] b);
    logic [GF_M-1:0] acc;
    logic [GF_M-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gfTimesAlpha(sh);
    end
    return acc;
  endfunction

endpackage

// File: rtl/bch_syn_ctrl.sv
module bch_syn_ctrl
  import bch_syn_pkg::*;
#(
  parameter int CodeLen = CODE_N
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       validIn,
  output synStrobe_t strbOut,
  output logic       doneOut
);

  localparam int CntW = $clog2(CodeLen);
  localparam logic [CntW-1:0] LastIdx = CntW'(CodeLen - 1);

  typedef enum logic {IDLE, RUN} ctrlState_t;

  ctrlState_t state;
  logic [CntW-1:0] bitCnt;
  logic lastBit;

  always_comb begin
    strbOut.clear = startIn;
    strbOut.shift = (state == RUN) && validIn && !startIn;
    lastBit       = strbOut.shift && (bitCnt == LastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      bitCnt  <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= lastBit;
      if (startIn) begin
        state  <= RUN;
        bitCnt <= '0;
      end else if (lastBit) begin
        state  <= IDLE;
        bitCnt <= '0;
      end else if (strbOut.shift) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R7: after completion the controller accepts nothing until a start
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> state == IDLE);

  // R3: the bit counter never passes the word length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LastIdx);

endmodule

// File: rtl/bch_syn_dp.sv
module bch_syn_dp
  import bch_syn_pkg::*;
#(
  parameter int FieldW = GF_M,
  parameter int SynCnt = NUM_SYN
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  synStrobe_t                    strbIn,
  input  logic                          bitIn,
  output logic [SynCnt-1:0][FieldW-1:0] synOut,
  output logic                          zeroOut
);

  logic [SynCnt-1:0][FieldW-1:0] synReg;

  for (genvar j = 0; j < SynCnt; j++) begin : g_syn
    logic [FieldW-1:0] stepVal;
    always_comb begin
      stepVal = gfTimesAlphaPow(synReg[j], j + 1);
      stepVal[0] = stepVal[0] ^ bitIn;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               synReg[j] <= '0;
      else if (strbIn.clear)   synReg[j] <= '0;
      else if (strbIn.shift)   synReg[j] <= stepVal;
    end
  end

  assign synOut  = synReg;
  assign zeroOut = (synReg == '0);

  // R2: a start leaves every syndrome at zero
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strbIn.clear |=> (synReg == '0));

  // R6: no strobe, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strbIn.clear && !strbIn.shift) |=> $stable(synReg));

endmodule

// File: rtl/bch_syn_top.sv
module bch_syn_top
  import bch_syn_pkg::*;
#(
  parameter int FieldW  = GF_M,
  parameter int SynCnt  = NUM_SYN,
  parameter int CodeLen = CODE_N
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startIn,
  input  logic                          validIn,
  input  logic                          bitIn,
  output logic [SynCnt-1:0][FieldW-1:0] synOut,
  output logic                          zeroOut,
  output logic                          doneOut
);

  synStrobe_t strb;

  bch_syn_ctrl #(.CodeLen(CodeLen)) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .validIn(validIn),
    .strbOut(strb), .doneOut(doneOut)
  );

  bch_syn_dp #(.FieldW(FieldW), .SynCnt(SynCnt)) uDp (
    .clk(clk), .rstN(rstN), .strbIn(strb), .bitIn(bitIn),
    .synOut(synOut), .zeroOut(zeroOut)
  );

  // R9: even syndromes are squares of the lower ones once a word is complete
  a_r9_square: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (synOut[1] == gfMul(synOut[0], synOut[0]) &&
                 synOut[3] == gfMul(synOut[1], synOut[1]) &&
                 synOut[5] == gfMul(synOut[2], synOut[2])));

  // R10: the zero flag drops whenever a syndrome is nonzero
  a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (synOut != '0) |-> !zeroOut);

endmodule

// File: tb/bch_syn_top_test.sv
`timescale 1ns/1ps
module bch_syn_top_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0, validIn = 1'b0, bitIn = 1'b0;
  logic [5:0][4:0] synOut;
  logic zeroOut, doneOut;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  bch_syn_top uut (.clk(clk), .rstN(rstN), .startIn(startIn), .validIn(validIn),
                   .bitIn(bitIn), .synOut(synOut), .zeroOut(zeroOut), .doneOut(doneOut));

  function automatic logic [4:0] tbMul(input logic [4:0] a, input logic [4:0] b);
    logic [9:0] p = '0;
    for (int i = 0; i < 5; i++) if (b[i]) p = p ^ (10'(a) << i);
    for (int d = 9; d >= 5; d--) if (p[d]) p = p ^ (10'b100101 << (d - 5));
    return p[4:0];
  endfunction

  function automatic logic [4:0] tbPow(input int e);
    logic [4:0] r = 5'd1;
    for (int i = 0; i < e % 31; i++) r = tbMul(r, 5'd2);
    return r;
  endfunction

  function automatic logic [4:0] tbSyn(input logic [30:0] w, input int j);
    logic [4:0] s = '0;
    for (int i = 0; i < 31; i++) if (w[i]) s = s ^ tbPow(i * j);
    return s;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart(input logic withBit);
    @(negedge clk); startIn = 1'b1; validIn = withBit; bitIn = withBit;
    @(negedge clk); startIn = 1'b0; validIn = 1'b0;
  endtask

  // sends a word, checks done timing (R5) and the syndromes (R3, R9, R10)
  task automatic runWord(input logic [30:0] w, input bit gaps, input string tag);
    logic [4:0] s1, s2, s3;
    int doneEarly = 0;
    for (int i = 30; i >= 0; i--) begin
      if (gaps && (i % 4 == 1)) begin
        @(negedge clk); validIn = 1'b0; bitIn = 1'b1;
        if (doneOut) doneEarly++;
      end
      @(negedge clk); validIn = 1'b1; bitIn = w[i];
      if (doneOut) doneEarly++;
    end
    @(negedge clk); validIn = 1'b0;
    check({"R5 no early done ", tag}, doneEarly, 0);
    check({"R5 done after last bit ", tag}, doneOut, 1);
    for (int j = 1; j <= 6; j++)
      check($sformatf("R3 S%0d %s", j, tag), synOut[j-1], tbSyn(w, j));
    s1 = synOut[0]; s2 = synOut[1]; s3 = synOut[2];
    check({"R9 squares ", tag}, {synOut[1], synOut[3], synOut[5]},
          {tbMul(s1, s1), tbMul(s2, s2), tbMul(s3, s3)});
    check({"R10 zero flag ", tag}, zeroOut, (synOut == '0) ? 1 : 0);
    @(negedge clk);
    check({"R5 done single cycle ", tag}, doneOut, 0);
  endtask

  task automatic testReset();
    check("R1 reset syndromes", synOut, 0);
    check("R1 reset done", doneOut, 0);
    check("R1 reset zero flag", zeroOut, 1);
  endtask

  task automatic testBeforeStart();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); validIn = 1'b1; bitIn = 1'b1;
    end
    @(negedge clk); validIn = 1'b0;
    check("R8 bits before start ignored", synOut, 0);
    check("R8 no done before start", doneOut, 0);
  endtask

  task automatic testCodewords();
    pulseStart(1'b0);
    runWord(31'h0, 1'b0, "zero word");
    check("R4 zero word flag", zeroOut, 1);
    pulseStart(1'b0);
    runWord(31'h7FFF_FFFF, 1'b0, "ones word");
    check("R4 ones word syndromes", synOut, 0);
    check("R4 ones word flag", zeroOut, 1);
  endtask

  task automatic testErrors();
    pulseStart(1'b0);
    runWord(31'h4000_0000, 1'b0, "error x30");
    check("R10 single error flag", zeroOut, 0);
    pulseStart(1'b0);
    runWord(31'h0000_0001, 1'b0, "error x0");
    pulseStart(1'b0);
    runWord(31'h7FFF_FFFF ^ 31'h0010_0202, 1'b0, "three errors");
    check("R10 three errors flag", zeroOut, 0);
    pulseStart(1'b0);
    runWord(31'h2A5C_39E1, 1'b0, "pattern a");
  endtask

  task automatic testGaps();
    pulseStart(1'b0);
    runWord(31'h1357_9BDF, 1'b1, "R6 gaps");
  endtask

  task automatic testExtraBits();
    logic [5:0][4:0] held;
    int doneSeen = 0;
    pulseStart(1'b0);
    runWord(31'h5566_7788, 1'b0, "before extra");
    held = synOut;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); validIn = 1'b1; bitIn = i[0];
      if (doneOut) doneSeen++;
    end
    @(negedge clk); validIn = 1'b0;
    if (doneOut) doneSeen++;
    check("R7 extra bits ignored", synOut, held);
    check("R7 no done on extra bits", doneSeen, 0);
  endtask

  task automatic testStart();
    // R2: start with a bit offered clears, bit not taken
    pulseStart(1'b1);
    check("R2 start clears", synOut, 0);
    // partial word then restart
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); validIn = 1'b1; bitIn = 1'b1;
    end
    pulseStart(1'b0);
    check("R2 restart clears partial", synOut, 0);
    runWord(31'h0F0F_3C3C, 1'b0, "R2 after restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testBeforeStart();
    testCodewords();
    testErrors();
    testGaps();
    testExtraBits();
    testStart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule